// File: doc/BRIEF.md
# Barrier Flag Copy Readout

Each processor keeps a local copy of a board-wide array of barrier-busy flags, so that application code can test a flag without a round trip to the system side. Whenever a flag changes on the board, a broadcast message arrives carrying the barrier unit, the line within that unit and the new value. The block writes that value into the matching bit of its local copy.

Two privileged control registers each hold a valid bit and a flag selector. Each register has its own application read port. That port presents the selected mirror bit while the valid bit is set, and 0 while it is clear. Supervisor software programs the registers through a small access interface. Any access that lacks supervisor privilege, or that targets an address that is not a register, is refused with an error pulse. A refused access returns 0 and leaves every register as it was.

Top module: `bfc_flag_copy`

## Requirements
- R1: After reset the flag copy holds all zeros, both control registers read back 0, and both read ports output 0.
- R2: A broadcast with `bc_valid` high writes `bc_value` into flag index `bc_unit*8 + bc_line` at that clock edge. No other flag bit changes.
- R3: While a control register's valid bit (bit 63) is 0, its read port outputs 0 whatever its selector holds and whatever the flag copy holds.
- R4: While a control register's valid bit is 1, its read port outputs flag `unit*8 + line`. The unit is taken from register bit 3 and the line from register bits 2:0.
- R5: The register at offset 0x0 steers `app_flag[0]` and the register at offset 0x8 steers `app_flag[1]`. A write to one register never changes the other register or the other port.
- R6: A supervisor write (`cfg_req`, `cfg_write` and `cfg_priv` all high, offset 0x0 or 0x8) takes effect at that clock edge. A supervisor read returns the register contents in the same cycle.
- R7: An access with `cfg_priv` low raises `cfg_err` in that cycle, returns `cfg_rdata` = 0 and changes no register.
- R8: When a broadcast and a read port hit the same flag in one cycle, the port shows the old value in that cycle and the new value from the next cycle on.
- R9: An access whose offset has any of bits 2:0 set is refused in the same way as R7: error pulse, read data 0, no change.
- R10: Only register bits 63, 3 and 2:0 are stored. Every other bit reads back as 0, whatever value was written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bc_valid | input | 1 | Broadcast flag-change strobe |
| bc_unit | input | 1 | Barrier unit number of the change |
| bc_line | input | 3 | Line number within the unit |
| bc_value | input | 1 | New flag value |
| cfg_req | input | 1 | Control register access strobe |
| cfg_write | input | 1 | 1 for a write, 0 for a read |
| cfg_priv | input | 1 | Access is made at supervisor level |
| cfg_addr | input | 4 | Byte offset of the register (0x0 or 0x8) |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data, valid in the same cycle as the request |
| cfg_err | output | 1 | Access refused, a single-cycle pulse |
| app_flag | output | 2 | Application read ports, one for each control register |

## Verification
The assertions assume that each broadcast names a flag that exists, which holds trivially at the default geometry. They also assume that the reset is synchronous, so no state changes between edges. They assume that the control inputs are steady for the whole cycle around the rising edge. The bench meets these assumptions by driving every input 1 ns after a rising edge and holding it until the next edge. It releases reset only in that same window. It uses broadcast fields only within the 16-flag range.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  // Default geometry of the flag copy
  localparam int DEF_UNITS  = 2;
  localparam int DEF_LINES  = 8;
  localparam int DEF_PORTS  = 2;
  localparam int DEF_DATA_W = 64;

  // Outcome of one control-interface access
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_READ   = 2'd1,
    ACC_WRITE  = 2'd2,
    ACC_REJECT = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/bfc_mirror.sv
module bfc_mirror #(
  parameter int FLAGS = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_val,
  output logic [FLAGS-1:0] flags,
  output logic [FLAGS-1:0] upd_onehot
);

  // One-hot decode of the broadcast target
  function automatic logic [FLAGS-1:0] decode(input logic en, input logic [IDX_W-1:0] idx);
    logic [FLAGS-1:0] r;
    r = '0;
    for (int i = 0; i < FLAGS; i++) begin
      if (en && (idx == IDX_W'(i))) r[i] = 1'b1;
    end
    return r;
  endfunction

  always_comb upd_onehot = decode(upd_en, upd_idx);

  for (genvar g = 0; g < FLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)             flags[g] <= 1'b0;
      else if (upd_onehot[g]) flags[g] <= upd_val;
    end
  end

endmodule

// File: rtl/bfc_ctrl_regs.sv
module bfc_ctrl_regs
  import bfc_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int PORTS     = 2,
  parameter int ADDR_W    = 4,
  parameter int ADDR_LSB  = 3,
  parameter int VALID_POS = 63,
  parameter int SEL_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req,
  input  logic                        wr,
  input  logic                        priv,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic                        err,
  output logic [PORTS-1:0]            valid_q,
  output logic [PORTS-1:0][SEL_W-1:0] sel_q,
  output acc_kind_e                   kind,
  output logic [PORTS-1:0]            wr_hit
);

  localparam int IDX_W = ADDR_W - ADDR_LSB;

  logic [IDX_W-1:0] reg_idx;
  logic             aligned;
  logic             in_range;
  logic             unused_wdata;

  function automatic logic is_aligned(input logic [ADDR_W-1:0] a);
    return a[ADDR_LSB-1:0] == '0;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic v, input logic [SEL_W-1:0] s);
    logic [DATA_W-1:0] w;
    w = '0;
    w[VALID_POS]   = v;
    w[SEL_W-1:0]   = s;
    return w;
  endfunction

  always_comb begin
    reg_idx  = addr[ADDR_W-1:ADDR_LSB];
    aligned  = is_aligned(addr);
    in_range = ({1'b0, reg_idx} < (IDX_W+1)'(PORTS));
    if (!req)                              kind = ACC_NONE;
    else if (!priv || !aligned || !in_range) kind = ACC_REJECT;
    else if (wr)                           kind = ACC_WRITE;
    else                                   kind = ACC_READ;
  end

  always_comb err = (kind == ACC_REJECT);

  always_comb begin
    rdata = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (kind == ACC_READ && reg_idx == IDX_W'(p)) rdata = pack_ctrl(valid_q[p], sel_q[p]);
    end
  end

  // Bits outside the stored fields are dropped on purpose
  always_comb unused_wdata = ^wdata;

  for (genvar p = 0; p < PORTS; p++) begin : g_reg
    always_comb wr_hit[p] = (kind == ACC_WRITE) && (reg_idx == IDX_W'(p));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[p] <= 1'b0;
        sel_q[p]   <= '0;
      end else if (wr_hit[p]) begin
        valid_q[p] <= wdata[VALID_POS];
        sel_q[p]   <= wdata[SEL_W-1:0];
      end
    end
  end

endmodule

// File: rtl/bfc_read_port.sv
module bfc_read_port #(
  parameter int FLAGS = 16,
  parameter int SEL_W = 4
) (
  input  logic             valid,
  input  logic [SEL_W-1:0] sel,
  input  logic [FLAGS-1:0] flags,
  output logic             flag_o
);

  function automatic logic pick(input logic [FLAGS-1:0] f, input logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < FLAGS; i++) begin
      if (s == SEL_W'(i)) r = f[i];
    end
    return r;
  endfunction

  always_comb flag_o = valid ? pick(flags, sel) : 1'b0;

endmodule

// File: rtl/bfc_flag_copy.sv
module bfc_flag_copy
  import bfc_pkg::*;
#(
  parameter int DATA_W     = DEF_DATA_W,
  parameter int PORTS      = DEF_PORTS,
  parameter int UNITS      = DEF_UNITS,
  parameter int LINES      = DEF_LINES,
  parameter int ADDR_W     = 4,
  parameter int REG_STRIDE = 8,
  parameter int VALID_POS  = 63,
  localparam int LINE_W    = $clog2(LINES),
  localparam int UNIT_W    = (UNITS > 1) ? $clog2(UNITS) : 1,
  localparam int FLAGS     = UNITS * LINES,
  localparam int SEL_W     = $clog2(FLAGS),
  localparam int ADDR_LSB  = $clog2(REG_STRIDE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bc_valid,
  input  logic [UNIT_W-1:0] bc_unit,
  input  logic [LINE_W-1:0] bc_line,
  input  logic              bc_value,
  input  logic              cfg_req,
  input  logic              cfg_write,
  input  logic              cfg_priv,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_err,
  output logic [PORTS-1:0]  app_flag
);

  // Flat flag number of a (unit, line) pair
  function automatic logic [SEL_W-1:0] flag_index(input logic [UNIT_W-1:0] u,
                                                  input logic [LINE_W-1:0] l);
    return SEL_W'(int'(u) * LINES + int'(l));
  endfunction

  logic [SEL_W-1:0]            bc_idx;
  logic [FLAGS-1:0]            flags_q;
  logic [FLAGS-1:0]            bc_onehot;
  logic [PORTS-1:0]            ctrl_valid;
  logic [PORTS-1:0][SEL_W-1:0] ctrl_sel;
  logic [PORTS-1:0]            ctrl_wr_hit;
  acc_kind_e                   acc_kind;

  always_comb bc_idx = flag_index(bc_unit, bc_line);

  bfc_mirror #(.FLAGS(FLAGS), .IDX_W(SEL_W)) u_mirror (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (bc_valid),
    .upd_idx    (bc_idx),
    .upd_val    (bc_value),
    .flags      (flags_q),
    .upd_onehot (bc_onehot)
  );

  bfc_ctrl_regs #(
    .DATA_W    (DATA_W),
    .PORTS     (PORTS),
    .ADDR_W    (ADDR_W),
    .ADDR_LSB  (ADDR_LSB),
    .VALID_POS (VALID_POS),
    .SEL_W     (SEL_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (cfg_req),
    .wr      (cfg_write),
    .priv    (cfg_priv),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .err     (cfg_err),
    .valid_q (ctrl_valid),
    .sel_q   (ctrl_sel),
    .kind    (acc_kind),
    .wr_hit  (ctrl_wr_hit)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    bfc_read_port #(.FLAGS(FLAGS), .SEL_W(SEL_W)) u_port (
      .valid  (ctrl_valid[p]),
      .sel    (ctrl_sel[p]),
      .flags  (flags_q),
      .flag_o (app_flag[p])
    );
  end

endmodule

// File: rtl/bfc_flag_copy_chk.sv
module bfc_flag_copy_chk
  import bfc_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int PORTS     = 2,
  parameter int FLAGS     = 16,
  parameter int SEL_W     = 4,
  parameter int VALID_POS = 63
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bc_valid,
  input logic [SEL_W-1:0]            bc_idx,
  input logic                        bc_value,
  input logic [FLAGS-1:0]            bc_onehot,
  input logic                        cfg_req,
  input logic                        cfg_priv,
  input logic                        cfg_err,
  input logic [DATA_W-1:0]           cfg_rdata,
  input logic [PORTS-1:0]            app_flag,
  input logic [FLAGS-1:0]            flags_q,
  input logic [PORTS-1:0]            ctrl_valid,
  input logic [PORTS-1:0][SEL_W-1:0] ctrl_sel,
  input logic [PORTS-1:0]            ctrl_wr_hit,
  input acc_kind_e                   acc_kind
);

  localparam logic [DATA_W-1:0] KEEP = (DATA_W'(1) << VALID_POS) | DATA_W'((1 << SEL_W) - 1);

  // R2: the addressed flag takes the broadcast value
  a_r2_update_lands: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |=> flags_q[$past(bc_idx)] == $past(bc_value));

  // R2: flags not addressed keep their value
  a_r2_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q ^ $past(flags_q)) & ~$past(bc_onehot)) == '0);

  // R7: an unprivileged access leaves both registers untouched
  a_r7_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_priv) |=> ($stable(ctrl_valid) && $stable(ctrl_sel)));

  // R7: a refused access returns zero data
  a_r7_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> cfg_rdata == '0);

  // R9: only an accepted write moves register state
  a_r9_only_writes_change: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind != ACC_WRITE) |=> ($stable(ctrl_valid) && $stable(ctrl_sel)));

  // R5: at most one register is written per access
  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_wr_hit));

  // R10: bits outside the stored fields read as zero
  a_r10_clean_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~KEEP) == '0);

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    // R3: a cleared valid bit forces the port low
    a_r3_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_valid[p] |-> !app_flag[p]);
    // R4: a set valid bit exposes the selected flag
    a_r4_selected_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_valid[p] |-> app_flag[p] == flags_q[ctrl_sel[p]]);
  end

endmodule

bind bfc_flag_copy bfc_flag_copy_chk #(
  .DATA_W    (DATA_W),
  .PORTS     (PORTS),
  .FLAGS     (FLAGS),
  .SEL_W     (SEL_W),
  .VALID_POS (VALID_POS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bc_valid    (bc_valid),
  .bc_idx      (bc_idx),
  .bc_value    (bc_value),
  .bc_onehot   (bc_onehot),
  .cfg_req     (cfg_req),
  .cfg_priv    (cfg_priv),
  .cfg_err     (cfg_err),
  .cfg_rdata   (cfg_rdata),
  .app_flag    (app_flag),
  .flags_q     (flags_q),
  .ctrl_valid  (ctrl_valid),
  .ctrl_sel    (ctrl_sel),
  .ctrl_wr_hit (ctrl_wr_hit),
  .acc_kind    (acc_kind)
);

// File: tb/sim_bfc_flag_copy.sv
`timescale 1ns/1ps
module sim_bfc_flag_copy;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bc_valid = 1'b0;
  logic [0:0]  bc_unit = '0;
  logic [2:0]  bc_line = '0;
  logic        bc_value = 1'b0;
  logic        cfg_req = 1'b0;
  logic        cfg_write = 1'b0;
  logic        cfg_priv = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        cfg_err;
  logic [1:0]  app_flag;

  always #5 clk = ~clk;

  bfc_flag_copy u0 (
    .clk(clk), .rst_n(rst_n),
    .bc_valid(bc_valid), .bc_unit(bc_unit), .bc_line(bc_line), .bc_value(bc_value),
    .cfg_req(cfg_req), .cfg_write(cfg_write), .cfg_priv(cfg_priv),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .app_flag(app_flag)
  );

  typedef struct {
    string       tag;
    int          kind;   // 0,1 app ports, 2 rdata, 3 err
    logic [63:0] exp;
  } item_t;

  item_t q[$];
  int tests = 0;
  int fails = 0;

  // Reference state kept from the requirements
  logic [15:0] m_flags = '0;
  logic [63:0] m_reg [2] = '{64'd0, 64'd0};
  localparam logic [63:0] STORED = 64'h8000_0000_0000_000F;

  function automatic logic port_model(input int p);
    if (m_reg[p][63] == 1'b0) return 1'b0;
    return (m_flags >> (m_reg[p][3] * 8 + m_reg[p][2:0])) & 16'd1;
  endfunction

  task automatic push(input string tag, input int kind, input logic [63:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic step(input string tag,
                      input logic bv, input logic bu, input logic [2:0] bl, input logic bval,
                      input logic rq, input logic wr, input logic pv,
                      input logic [3:0] ad, input logic [63:0] wd);
    logic e_err;
    logic [63:0] e_rd;
    @(posedge clk);
    #1;
    bc_valid = bv; bc_unit = bu; bc_line = bl; bc_value = bval;
    cfg_req = rq; cfg_write = wr; cfg_priv = pv; cfg_addr = ad; cfg_wdata = wd;
    e_err = rq && (!pv || ad[2:0] != 3'd0);
    e_rd  = (rq && !wr && !e_err) ? m_reg[ad[3]] : 64'd0;
    push(tag, 0, {63'd0, port_model(0)});
    push(tag, 1, {63'd0, port_model(1)});
    push(tag, 2, e_rd);
    push(tag, 3, {63'd0, e_err});
    if (bv) m_flags[bu * 8 + bl] = bval;
    if (rq && wr && !e_err) m_reg[ad[3]] = wd & STORED;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 3'd0, 0, 0, 0, 0, 4'h0, 64'd0);
  endtask
  task automatic bcast(input string tag, input logic u, input logic [2:0] l, input logic v);
    step(tag, 1, u, l, v, 0, 0, 0, 4'h0, 64'd0);
  endtask
  task automatic cwr(input string tag, input logic pv, input logic [3:0] ad, input logic [63:0] wd);
    step(tag, 0, 0, 3'd0, 0, 1, 1, pv, ad, wd);
  endtask
  task automatic crd(input string tag, input logic pv, input logic [3:0] ad);
    step(tag, 0, 0, 3'd0, 0, 1, 0, pv, ad, 64'd0);
  endtask

  // Monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {63'd0, app_flag[0]};
        1: act = {63'd0, app_flag[1]};
        2: act = cfg_rdata;
        default: act = {63'd0, cfg_err};
      endcase
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    idle("R1 reset ports");
    crd("R1 reset reg0", 1, 4'h0);
    crd("R1 reset reg1", 1, 4'h8);
    // R2 + R3: flag set while port disabled
    bcast("R2 R3 set flag 5 gated", 0, 3'd5, 1);
    // R6: program reg0 to flag 5
    cwr("R6 write reg0", 1, 4'h0, 64'h8000_0000_0000_0005);
    idle("R4 R5 port0 sees flag 5");
    crd("R6 read reg0", 1, 4'h0);
    // R10: junk bits dropped
    cwr("R10 write reg1 junk", 1, 4'h8, 64'hFFFF_0000_1234_567C);
    crd("R10 read reg1 masked", 1, 4'h8);
    // R8: same-cycle broadcast on selected flag 12
    bcast("R8 old value this cycle", 1, 3'd4, 1);
    idle("R8 new value next cycle");
    bcast("R8 clear flag 12", 1, 3'd4, 0);
    idle("R8 cleared next cycle");
    // R7: unprivileged accesses
    cwr("R7 unpriv write", 0, 4'h0, 64'd0);
    crd("R7 reg0 unchanged", 1, 4'h0);
    crd("R7 unpriv read", 0, 4'h8);
    // R9: misaligned offset
    cwr("R9 misaligned write", 1, 4'h4, 64'h0);
    crd("R9 misaligned read", 1, 4'hC);
    crd("R9 reg0 unchanged", 1, 4'h0);
    // R3: valid cleared with selector on a set flag
    bcast("R3 set flag 12", 1, 3'd4, 1);
    cwr("R3 clear valid reg0", 1, 4'h0, 64'h0000_0000_0000_000C);
    idle("R3 R5 port0 low port1 high");
    // R2 + R4: pattern then sweep reg1 selector over every flag
    for (int i = 0; i < 16; i++) begin
      logic [15:0] pat;
      pat = 16'hA5C3;
      bcast("R2 pattern load", i[3], i[2:0], pat[i]);
    end
    for (int i = 0; i < 16; i++) begin
      cwr("R4 R6 sweep select", 1, 4'h8, {1'b1, 59'd0, i[3:0]});
      idle("R4 sweep read");
    end
    idle("R2 final");
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule